// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block computes single-error-correcting Hamming check bits over the byte stream that flows between a controller and a NAND flash page. Bytes offered on an 8-bit bus with a valid strobe are folded into a running parity while the enable control is high. The first 256 accepted bytes go into one accumulator and the next 256 go into a second one. Each accumulator keeps 16 bits of line parity, which is indexed by the byte's position, and 6 bits of column parity, which is indexed by the bit position inside a byte.

Software reads the results through a small bank of 16-bit registers. The bank is loaded only when the enable control falls from 1 to 0. Because of this, firmware drops the enable after the last page byte and then reads the check bits at leisure. A separate clear control restarts the running parity and the byte count for the next page. The clear does not disturb the captured bank.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset every readable register (selects 0 to 7) reads 16'hFFFF.
- R2: Register 0 holds the line parity of the first 256-byte half and register 2 holds that of the second half. The byte address is the byte's position within its half, counted from 0. Bit 2j is the XOR of the byte parities (the XOR of all 8 bits) of the accepted bytes whose address bit j is 0. Bit 2j+1 is the same XOR for address bit j equal to 1, for j = 0..7.
- R3: Register 1 holds the column parity of the first half in bits [7:2], and register 3 holds that of the second half. Bit 2+2k is the XOR of all data bits, over all accepted bytes of the half, whose bit index has bit k equal to 0. Bit 3+2k covers the bit indices with bit k equal to 1, for k = 0..2. Bits [15:8] and [1:0] of these registers read 1.
- R4: The readable registers change only at a clock edge where the enable is sampled 0 after having been sampled 1 at the previous edge. At that edge they take the running parity accumulated before it. In every other cycle they keep their contents.
- R5: When the clear control is sampled 1, the running parity and the byte count go to zero, and clear wins over a byte offered in the same cycle. The readable registers are not cleared. A capture in the same cycle uses the parity from before the clear.
- R6: Accepted bytes 0..255 after a clear feed the first half and bytes 256..511 feed the second half. After 512 bytes, further bytes are ignored until a clear.
- R7: A byte strobe while the enable is sampled 0 changes neither the running parity nor the byte count.
- R8: Register 4 and selects 5 to 7 always read 16'hFFFF.
- R9: The read data follows the register select combinationally, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Accumulate enable; its 1-to-0 edge loads the readable bank |
| ecc_clr | input | 1 | Clears running parity and byte count |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| rd_sel | input | 3 | Register select |
| rd_data | output | 16 | Selected register contents |

## Verification
The bench builds the block with its default parameters: 8-bit data, 256-byte halves, two halves, 16-bit registers and non-inverted parity. With a page of only 512 bytes, the bench can run full pages, the crossing from one half into the other, and saturation past the end of the page within a few thousand cycles. It can also hit the narrow timing cases. These include a capture and a clear in the same cycle, and a clear and a byte in the same cycle. They also include strobes while disabled and a check that the bank holds while enable stays high.

// File: rtl/nhe_pkg.sv
package nhe_pkg;

   // Mask of the bit positions whose index has bit k set (up to 64 bits).
   function automatic logic [63:0] col_mask(input int k);
      logic [63:0] m;
      for (int b = 0; b < 64; b++) m[b] = ((b >> k) & 1) == 1;
      return m;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/nhe_byte_ctr.sv
module nhe_byte_ctr #(
   parameter int TOTAL = 512,
   parameter int CNT_W = $clog2(TOTAL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             full
);

   assign full = (cnt == CNT_W'(TOTAL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr)              cnt <= '0;
      else if (step && !full)    cnt <= cnt + 1'b1;
   end

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(TOTAL));

   p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/nhe_half_acc.sv
module nhe_half_acc import nhe_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter int CB_W   = $clog2(DATA_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                acc_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   data,
   output logic [2*ADDR_W-1:0] lp,
   output logic [2*CB_W-1:0]   cp
);

   logic                byte_par;
   logic [2*ADDR_W-1:0] lp_flip;
   logic [2*CB_W-1:0]   cp_flip;

   assign byte_par = ^data;

   // Line parity: one pair per address bit, low slot for bit = 0.
   for (genvar j = 0; j < ADDR_W; j++) begin : g_line
      assign lp_flip[2*j]   = byte_par & ~addr[j];
      assign lp_flip[2*j+1] = byte_par &  addr[j];
   end

   // Column parity: one pair per bit-index bit, low slot for bit = 0.
   for (genvar k = 0; k < CB_W; k++) begin : g_col
      localparam logic [DATA_W-1:0] SEL = DATA_W'(col_mask(k));
      assign cp_flip[2*k]   = ^(data & ~SEL);
      assign cp_flip[2*k+1] = ^(data &  SEL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lp <= '0;
         cp <= '0;
      end else if (clr) begin
         lp <= '0;
         cp <= '0;
      end else if (acc_en) begin
         lp <= lp ^ lp_flip;
         cp <= cp ^ cp_flip;
      end
   end

   p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (lp == '0 && cp == '0));

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_en && !clr) |=> ($stable(lp) && $stable(cp)));

endmodule

// File: rtl/nhe_read_bank.sv
module nhe_read_bank #(
   parameter int NUM_HALVES = 2,
   parameter int LP_W       = 16,
   parameter int CP_W       = 6,
   parameter int REG_W      = 16,
   parameter int COL_LSB    = 2,
   parameter bit PARITY_INV = 1'b0,
   parameter int NUM_REGS   = 2*NUM_HALVES + 1,
   parameter int SEL_W      = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cap,
   input  logic [NUM_HALVES*LP_W-1:0] lp_all,
   input  logic [NUM_HALVES*CP_W-1:0] cp_all,
   input  logic [SEL_W-1:0]           rd_sel,
   output logic [REG_W-1:0]           rd_data
);

   logic [NUM_HALVES*LP_W-1:0] lp_eff;
   logic [NUM_HALVES*CP_W-1:0] cp_eff;
   logic [REG_W-1:0]           cap_val [NUM_REGS];
   logic [REG_W-1:0]           bank_q  [NUM_REGS];

   if (PARITY_INV) begin : g_inv
      assign lp_eff = ~lp_all;
      assign cp_eff = ~cp_all;
   end else begin : g_plain
      assign lp_eff = lp_all;
      assign cp_eff = cp_all;
   end

   for (genvar h = 0; h < NUM_HALVES; h++) begin : g_pack
      always_comb begin
         cap_val[2*h] = '1;
         cap_val[2*h][LP_W-1:0] = lp_eff[h*LP_W +: LP_W];
         cap_val[2*h+1] = '1;
         cap_val[2*h+1][COL_LSB +: CP_W] = cp_eff[h*CP_W +: CP_W];
      end
   end

   for (genvar r = 2*NUM_HALVES; r < NUM_REGS; r++) begin : g_spare
      assign cap_val[r] = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_REGS; r++) bank_q[r] <= '1;
      end else if (cap) begin
         for (int r = 0; r < NUM_REGS; r++) bank_q[r] <= cap_val[r];
      end
   end

   always_comb begin
      rd_data = '1;
      for (int r = 0; r < NUM_REGS; r++)
         if (rd_sel == SEL_W'(r)) rd_data = bank_q[r];
   end

   p_spare_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel >= SEL_W'(2*NUM_HALVES)) |-> (rd_data == '1));

   p_col_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel < SEL_W'(2*NUM_HALVES) && rd_sel[0])
         |-> (&rd_data[COL_LSB-1:0] && &rd_data[REG_W-1:COL_LSB+CP_W]));

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc import nhe_pkg::*; #(
   parameter int  DATA_W     = 8,
   parameter int  HALF_BYTES = 256,
   parameter int  NUM_HALVES = 2,
   parameter int  REG_W      = 16,
   parameter int  COL_LSB    = 2,
   parameter bit  PARITY_INV = 1'b0,
   localparam int NUM_REGS   = 2*NUM_HALVES + 1,
   localparam int SEL_W      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ecc_en,
   input  logic              ecc_clr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [REG_W-1:0]  rd_data
);

   localparam int ADDR_W = $clog2(HALF_BYTES);
   localparam int CB_W   = $clog2(DATA_W);
   localparam int LP_W   = 2*ADDR_W;
   localparam int CP_W   = 2*CB_W;
   localparam int TOTAL  = HALF_BYTES*NUM_HALVES;
   localparam int CNT_W  = $clog2(TOTAL + 1);
   localparam int HIDX_W = CNT_W - ADDR_W;

   if (!is_pow2(DATA_W) || DATA_W < 2 || DATA_W > 64) begin : g_bad_data
      $error("DATA_W must be a power of two between 2 and 64");
   end
   if (!is_pow2(HALF_BYTES) || HALF_BYTES < 2) begin : g_bad_half
      $error("HALF_BYTES must be a power of two of at least 2");
   end
   if (LP_W > REG_W || COL_LSB + CP_W > REG_W || COL_LSB < 1) begin : g_bad_reg
      $error("parity fields do not fit the register width");
   end
   if (NUM_HALVES < 1) begin : g_bad_halves
      $error("NUM_HALVES must be at least 1");
   end

   logic                       en_q;
   logic                       cap;
   logic                       full;
   logic                       accept;
   logic [CNT_W-1:0]           cnt;
   logic [HIDX_W-1:0]          half_idx;
   logic [NUM_HALVES*LP_W-1:0] lp_all;
   logic [NUM_HALVES*CP_W-1:0] cp_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= ecc_en;
   end

   assign cap      = en_q & ~ecc_en;
   assign accept   = byte_vld & ecc_en & ~full;
   assign half_idx = cnt[CNT_W-1:ADDR_W];

   nhe_byte_ctr #(.TOTAL(TOTAL), .CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ecc_clr),
      .step  (accept),
      .cnt   (cnt),
      .full  (full)
   );

   for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      nhe_half_acc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CB_W(CB_W)) u_acc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (ecc_clr),
         .acc_en (accept && (half_idx == HIDX_W'(h))),
         .addr   (cnt[ADDR_W-1:0]),
         .data   (byte_data),
         .lp     (lp_all[h*LP_W +: LP_W]),
         .cp     (cp_all[h*CP_W +: CP_W])
      );
   end

   nhe_read_bank #(
      .NUM_HALVES (NUM_HALVES),
      .LP_W       (LP_W),
      .CP_W       (CP_W),
      .REG_W      (REG_W),
      .COL_LSB    (COL_LSB),
      .PARITY_INV (PARITY_INV),
      .NUM_REGS   (NUM_REGS),
      .SEL_W      (SEL_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (cap),
      .lp_all  (lp_all),
      .cp_all  (cp_all),
      .rd_sel  (rd_sel),
      .rd_data (rd_data)
   );

   // Bank cannot move across an edge at which enable was sampled high.
   p_hold_while_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_en |=> ($stable(rd_sel) -> $stable(rd_data)));

   p_disabled_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ecc_en && !ecc_clr) |=> $stable(cnt));

endmodule

// File: tb/sim_nand_hamming_ecc.sv
`timescale 1ns/1ps
module sim_nand_hamming_ecc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ecc_en = 1'b0, ecc_clr = 1'b0, byte_vld = 1'b0;
   logic [7:0]  byte_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [15:0] rd_data;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   nand_hamming_ecc u0 (
      .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
      .byte_vld(byte_vld), .byte_data(byte_data), .rd_sel(rd_sel),
      .rd_data(rd_data)
   );

   // ---------------- reference model from the requirements ----------------
   logic [15:0] m_lp [2];
   logic [5:0]  m_cp [2];
   logic [15:0] m_bank [5];
   int          m_cnt = 0;
   bit          m_en_q = 0;

   function automatic logic [15:0] exp_reg(int s);
      return (s < 5) ? m_bank[s] : 16'hFFFF;   // R8
   endfunction

   task automatic model_step(bit en, bit clr, bit vld, logic [7:0] d);
      if (m_en_q && !en) begin                  // R4 capture
         m_bank[0] = m_lp[0];
         m_bank[1] = {8'hFF, m_cp[0], 2'b11};
         m_bank[2] = m_lp[1];
         m_bank[3] = {8'hFF, m_cp[1], 2'b11};
         m_bank[4] = 16'hFFFF;
      end
      if (clr) begin                            // R5
         m_lp[0] = '0; m_lp[1] = '0; m_cp[0] = '0; m_cp[1] = '0; m_cnt = 0;
      end else if (vld && en && m_cnt < 512) begin
         int h = m_cnt / 256;
         int a = m_cnt % 256;
         bit bp = ^d;
         for (int j = 0; j < 8; j++)
            if ((a >> j) & 1) m_lp[h][2*j+1] ^= bp; else m_lp[h][2*j] ^= bp;
         for (int k = 0; k < 3; k++)
            for (int b = 0; b < 8; b++)
               if (d[b]) begin
                  if ((b >> k) & 1) m_cp[h][2*k+1] ^= 1'b1;
                  else              m_cp[h][2*k]   ^= 1'b1;
               end
         m_cnt++;
      end
      m_en_q = en;
   endtask

   task automatic cyc(bit en, bit clr, bit vld, logic [7:0] d);
      @(negedge clk);
      ecc_en = en; ecc_clr = clr; byte_vld = vld; byte_data = d;
      model_step(en, clr, vld, d);
      @(posedge clk);
   endtask

   // ---------------- scoreboard ----------------
   typedef struct {
      int          sel;
      logic [15:0] exp;
      string       tag;
   } item_t;
   item_t q[$];
   int pushed = 0, done = 0;

   task automatic push_all(string tag);
      cyc(m_en_q, 1'b0, 1'b0, 8'h00);          // go idle before reading
      for (int s = 0; s < 8; s++) begin
         item_t it;
         it.sel = s;
         it.exp = exp_reg(s);
         it.tag = (s >= 4) ? {tag, " R8 R9"} : {tag, " R9"};
         q.push_back(it);
         pushed++;
      end
      wait (done == pushed);
   endtask

   initial begin : monitor
      forever begin
         item_t it;
         wait (q.size() > 0);
         it = q.pop_front();
         @(negedge clk);
         rd_sel = 3'(it.sel);
         #1;
         checks++;
         if (rd_data !== it.exp) begin
            errors++;
            $display("FAIL %s sel=%0d actual=%h expected=%h",
                     it.tag, it.sel, rd_data, it.exp);
         end
         done++;
      end
   end

   function automatic logic [7:0] pat(int i, int seed);
      return 8'((i * seed + (i >> 3) * 13 + seed) ^ (i << 2));
   endfunction

   // ---------------- stimulus ----------------
   initial begin : driver
      m_lp[0] = '0; m_lp[1] = '0; m_cp[0] = '0; m_cp[1] = '0;
      for (int r = 0; r < 5; r++) m_bank[r] = 16'hFFFF;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      push_all("R1 reset");

      // first half, then fall of enable
      cyc(1, 0, 0, 8'h00);
      for (int i = 0; i < 256; i++) cyc(1, 0, 1, pat(i, 7));
      cyc(0, 0, 0, 8'h00);
      push_all("R2 R3 R4 first half captured");

      // bytes into the second half while enable stays high: bank holds
      cyc(1, 0, 0, 8'h00);
      for (int i = 0; i < 40; i++) cyc(1, 0, 1, pat(i, 11));
      push_all("R4 hold while enabled");
      cyc(0, 0, 0, 8'h00);
      push_all("R4 R6 second half captured");

      // strobes while disabled are ignored
      for (int i = 0; i < 30; i++) cyc(0, 0, 1, pat(i, 5) | 8'h01);
      cyc(1, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
      push_all("R7 strobes while disabled");

      // run past the end of the page
      cyc(1, 0, 0, 8'h00);
      for (int i = 0; i < 260; i++) cyc(1, 0, 1, pat(i, 19) | 8'h10);
      cyc(0, 0, 0, 8'h00);
      push_all("R6 saturation past 512");

      // capture and clear in the same cycle
      cyc(1, 0, 0, 8'h00);
      cyc(0, 1, 0, 8'h00);
      push_all("R5 capture beside clear");

      // clear with a same-cycle byte, then a short restart
      cyc(1, 1, 1, 8'hFF);
      cyc(1, 0, 1, 8'h80);
      cyc(1, 0, 1, 8'h00);
      cyc(1, 0, 1, 8'h0F);
      cyc(1, 0, 1, 8'hA5);
      cyc(0, 0, 0, 8'h00);
      push_all("R5 clear wins then restart R2 R3");

      // clear while disabled leaves the bank alone
      cyc(0, 1, 0, 8'h00);
      push_all("R5 bank survives clear");

      // an empty window after a clear captures zero parity
      cyc(1, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
      push_all("R2 R3 empty page");

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      #(5.0 * 100000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule